// File: doc/BRIEF.md
# Single-Buffer Bus-Master DMA Engine

This block sits on the peripheral side of a chip and moves one contiguous buffer between a local device data port and a simple memory request/response bus, one 32-bit word per beat. A host sets it up through a small register file. The host first stops the engine, then picks a direction, loads the buffer's bus address and its length in bytes, and finally issues a go command. From that point the engine runs on its own. When the last word has moved, it raises a level interrupt that stays high until the host acknowledges it.

The engine can reach only part of the bus address space. A parameter sets how many low address bits are reachable (24 by default). If the first byte or the last byte of the buffer lies outside that range, a go command is refused and an error flag is set. While a transfer runs, the engine ignores writes to the address and length registers, the direction commands and further go commands. Only the stop command and the interrupt acknowledge take effect. The number of bytes still to move can be read at any time.

Top module: `dma_engine`

## Requirements
- R1: After reset, the status word, the remaining-bytes word, `irq`, `mem_req`, `dev_rd_en` and `dev_wr_en` are all zero.
- R2: In memory-to-device mode, the engine issues ceil(len/4) memory reads (`mem_we`=0) at addresses base, base+4, and so on. Each word returned with `mem_ack` appears on `dev_wdata` with a one-cycle `dev_wr_en` pulse in the following cycle, in order.
- R3: In device-to-memory mode, each beat begins with a one-cycle `dev_rd_en` pop, during which the word on `dev_rdata` is taken. That word is then written to memory (`mem_we`=1) at base+4*i for beat i, for ceil(len/4) beats.
- R4: `irq` rises on the same clock edge at which the last beat is accepted, and `busy` falls on that edge. `irq` then stays high until an acknowledge command (code 5) is written.
- R5: A go command with length 0 at a reachable address raises `irq` on that same edge and never asserts `mem_req` or `dev_rd_en`.
- R6: A go command is refused when the start address, or (for a non-zero length) the address of the last byte, has any bit set at or above the reach parameter. In that case `busy` stays low and the error bit is set. The error bit is cleared by a stop command or by the next accepted go command.
- R7: While `busy` is high, writes to the address and length registers, the direction commands (codes 2 and 3) and the go command (code 4) have no effect on any readback or on the transfer.
- R8: A stop command (code 1) ends a running transfer on the write edge. `busy` and `mem_req` go low, no interrupt is raised, and the address and length registers accept new values afterwards.
- R9: At the go edge, the remaining-bytes word is loaded with the length. It falls by min(4, remaining) on each accepted beat, ends at 0 on completion, and holds its value after a stop.
- R10: Register map, with `reg_addr` selecting the register. Offset 0 is the command register: a write selects a command by `reg_wdata[2:0]` (1 stop, 2 memory-to-device, 3 device-to-memory, 4 go, 5 acknowledge), and the register reads as 0. Offset 1 is the address register and offset 2 the length register, both read/write. Offset 3 is status: bit0 busy, bit1 irq, bit2 error, bit3 direction (1 = memory-to-device). Offset 4 is the remaining-bytes word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on `reg_addr`) |
| irq | output | 1 | Level completion interrupt |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 32 | Memory byte address of the current beat |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | Beat accepted/returned on this edge |
| dev_rd_en | output | 1 | Pop one word from the device |
| dev_rdata | input | 32 | Device word, taken while `dev_rd_en` is high |
| dev_wr_en | output | 1 | Push one word to the device |
| dev_wdata | output | 32 | Word pushed to the device |

## Verification
A register write takes effect on the edge that samples it. Readback is combinational, so the bench reads status and the remaining-bytes word on the falling edge after a write, one register stage later. A memory beat is accepted on the rising edge after the bench's falling-edge `mem_ack`. The matching device push is then due one cycle later, so the bench logs beats as it grants them and logs device pushes on the falling edges where `dev_wr_en` is seen. The interrupt is due on the same edge as the last accepted beat. The bench therefore waits for `irq`, allows one further falling edge for the final device push, and only then compares counts, addresses and data against values computed from base, length and direction.

// File: rtl/dma_eng_pkg.sv
// Shared encodings for the DMA engine: register offsets, command codes,
// sequencer states. Assumes a 3-bit register offset space.
package dma_eng_pkg;
    localparam int REG_AW = 3;

    localparam logic [REG_AW-1:0] OFF_CMD  = 3'd0;
    localparam logic [REG_AW-1:0] OFF_ADDR = 3'd1;
    localparam logic [REG_AW-1:0] OFF_LEN  = 3'd2;
    localparam logic [REG_AW-1:0] OFF_STAT = 3'd3;
    localparam logic [REG_AW-1:0] OFF_REM  = 3'd4;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_STOP   = 3'd1,
        OP_TO_DEV = 3'd2,
        OP_TO_MEM = 3'd3,
        OP_GO     = 3'd4,
        OP_ACK    = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_MEM   = 2'd2
    } seq_st_e;
endpackage

// File: rtl/dma_eng_regs.sv
// Host register file: holds address, length and direction, decodes command
// writes into one-cycle pulses, and builds the readback word.
// Assumes busy comes from the sequencer; configuration is frozen while busy.
module dma_eng_regs
    import dma_eng_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              busy,
    input  logic              irq_flag,
    input  logic              err_flag,
    input  logic [REG_W-1:0]  remaining,
    output logic [REG_W-1:0]  cfg_addr,
    output logic [REG_W-1:0]  cfg_len,
    output logic              cfg_to_dev,
    output logic              start_cmd,
    output logic              stop_cmd,
    output logic              ack_cmd
);
    logic cmd_wr;
    op_e  op;

    // Decode a command-register write into its opcode.
    always_comb begin
        cmd_wr = reg_we && (reg_addr == OFF_CMD);
        op     = op_e'(reg_wdata[2:0]);
    end

    // Command pulses; go is accepted only while idle.
    assign start_cmd = cmd_wr && (op == OP_GO) && !busy;
    assign stop_cmd  = cmd_wr && (op == OP_STOP);
    assign ack_cmd   = cmd_wr && (op == OP_ACK);

    // Configuration registers, writable only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_addr   <= '0;
            cfg_len    <= '0;
            cfg_to_dev <= 1'b0;
        end else if (!busy) begin
            if (reg_we && reg_addr == OFF_ADDR) cfg_addr <= reg_wdata;
            if (reg_we && reg_addr == OFF_LEN)  cfg_len  <= reg_wdata;
            if (cmd_wr && op == OP_TO_DEV)      cfg_to_dev <= 1'b1;
            if (cmd_wr && op == OP_TO_MEM)      cfg_to_dev <= 1'b0;
        end
    end

    // Readback multiplexer.
    always_comb begin
        case (reg_addr)
            OFF_ADDR: reg_rdata = cfg_addr;
            OFF_LEN:  reg_rdata = cfg_len;
            OFF_STAT: reg_rdata = REG_W'({cfg_to_dev, err_flag, irq_flag, busy});
            OFF_REM:  reg_rdata = remaining;
            default:  reg_rdata = '0;
        endcase
    end

    a_r7_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cfg_addr));
    a_r7_len_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cfg_len));
    a_r7_dir_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cfg_to_dev));
endmodule

// File: rtl/dma_eng_reach.sv
// Reachability check: true when the buffer's first byte and (for a non-zero
// length) last byte both lie below 2**REACH_BITS. One extra bit catches
// wrap-around of address plus length.
module dma_eng_reach #(
    parameter int REG_W      = 32,
    parameter int REACH_BITS = 24
) (
    input  logic [REG_W-1:0] addr,
    input  logic [REG_W-1:0] len,
    output logic             in_range
);
    localparam int EW = REG_W + 1;
    localparam logic [EW-1:0] OUT_MASK = ~((EW'(1) << REACH_BITS) - EW'(1));

    logic [EW-1:0] first_b;
    logic [EW-1:0] last_b;

    // Compute the last byte address and test both ends against the mask.
    always_comb begin
        first_b  = {1'b0, addr};
        last_b   = first_b + {1'b0, len} - EW'(1);
        in_range = ((first_b & OUT_MASK) == '0) &&
                   ((len == '0) || ((last_b & OUT_MASK) == '0));
    end
endmodule

// File: rtl/dma_eng_seq.sv
// Transfer sequencer: walks the buffer one word per beat, pops or pushes the
// device port, and owns the interrupt, error and remaining-bytes state.
// Assumes start_cmd only arrives while idle and stop_cmd may come any time.
module dma_eng_seq
    import dma_eng_pkg::*;
#(
    parameter int REG_W  = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_cmd,
    input  logic              stop_cmd,
    input  logic              ack_cmd,
    input  logic              in_range,
    input  logic [REG_W-1:0]  cfg_addr,
    input  logic [REG_W-1:0]  cfg_len,
    input  logic              cfg_to_dev,
    output logic              busy,
    output logic              irq_flag,
    output logic              err_flag,
    output logic [REG_W-1:0]  remaining,
    output logic              mem_req,
    output logic              mem_we,
    output logic [REG_W-1:0]  mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              dev_rd_en,
    input  logic [DATA_W-1:0] dev_rdata,
    output logic              dev_wr_en,
    output logic [DATA_W-1:0] dev_wdata
);
    localparam logic [REG_W-1:0] STEP = REG_W'(DATA_W / 8);

    seq_st_e           state;
    logic              dir_q;
    logic [REG_W-1:0]  cur_addr;
    logic [REG_W-1:0]  step_now;
    logic [DATA_W-1:0] hold_q;

    // Bytes moved by the current beat: a full word or the tail.
    assign step_now = (remaining < STEP) ? remaining : STEP;

    // Main sequencer: start checks, beat accounting, interrupt and error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            dir_q     <= 1'b0;
            cur_addr  <= '0;
            remaining <= '0;
            hold_q    <= '0;
            irq_flag  <= 1'b0;
            err_flag  <= 1'b0;
            dev_wr_en <= 1'b0;
            dev_wdata <= '0;
        end else begin
            dev_wr_en <= 1'b0;
            if (ack_cmd) irq_flag <= 1'b0;
            if (stop_cmd) begin
                state    <= ST_IDLE;
                err_flag <= 1'b0;
            end else begin
                case (state)
                    ST_IDLE: if (start_cmd) begin
                        if (!in_range) begin
                            err_flag <= 1'b1;
                        end else begin
                            err_flag  <= 1'b0;
                            dir_q     <= cfg_to_dev;
                            cur_addr  <= cfg_addr;
                            remaining <= cfg_len;
                            if (cfg_len == '0) irq_flag <= 1'b1;
                            else state <= cfg_to_dev ? ST_MEM : ST_FETCH;
                        end
                    end
                    ST_FETCH: begin
                        hold_q <= dev_rdata;
                        state  <= ST_MEM;
                    end
                    ST_MEM: if (mem_ack) begin
                        cur_addr  <= cur_addr + STEP;
                        remaining <= remaining - step_now;
                        if (dir_q) begin
                            dev_wr_en <= 1'b1;
                            dev_wdata <= mem_rdata;
                        end
                        if (remaining <= STEP) begin
                            state    <= ST_IDLE;
                            irq_flag <= 1'b1;
                        end else if (!dir_q) begin
                            state <= ST_FETCH;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // Bus and device strobes derived from the state.
    assign busy      = (state != ST_IDLE);
    assign mem_req   = (state == ST_MEM);
    assign mem_we    = !dir_q;
    assign mem_addr  = cur_addr;
    assign mem_wdata = hold_q;
    assign dev_rd_en = (state == ST_FETCH);

    a_r4_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
        irq_flag && !ack_cmd |=> irq_flag);
    a_r2_push_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        dev_wr_en |-> $past(mem_req && mem_ack && !mem_we));
    a_r3_pop_then_write: assert property (@(posedge clk) disable iff (!rst_n)
        dev_rd_en && !stop_cmd |=> mem_req && mem_we);
    a_r8_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
        stop_cmd |=> !busy && !mem_req);
    a_r5_zero_len_done: assert property (@(posedge clk) disable iff (!rst_n)
        start_cmd && !stop_cmd && in_range && cfg_len == '0 |=> irq_flag && !busy);
    a_r6_refuse_unreachable: assert property (@(posedge clk) disable iff (!rst_n)
        start_cmd && !stop_cmd && !in_range |=> !busy && err_flag);
    a_r9_remaining_falls: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) && busy |-> remaining <= $past(remaining));
endmodule

// File: rtl/dma_engine.sv
// Top of the single-buffer DMA engine: joins the register file, the reach
// check and the transfer sequencer. Assumes DATA_W is a multiple of 8.
module dma_engine
    import dma_eng_pkg::*;
#(
    parameter int REG_W      = 32,
    parameter int DATA_W     = 32,
    parameter int REACH_BITS = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq,
    output logic              mem_req,
    output logic              mem_we,
    output logic [REG_W-1:0]  mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              dev_rd_en,
    input  logic [DATA_W-1:0] dev_rdata,
    output logic              dev_wr_en,
    output logic [DATA_W-1:0] dev_wdata
);
    logic             busy, err_flag, in_range;
    logic             start_cmd, stop_cmd, ack_cmd, cfg_to_dev;
    logic [REG_W-1:0] remaining, cfg_addr, cfg_len;

    dma_eng_regs #(.REG_W(REG_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
        .irq_flag(irq), .err_flag(err_flag), .remaining(remaining),
        .cfg_addr(cfg_addr), .cfg_len(cfg_len), .cfg_to_dev(cfg_to_dev),
        .start_cmd(start_cmd), .stop_cmd(stop_cmd), .ack_cmd(ack_cmd)
    );

    dma_eng_reach #(.REG_W(REG_W), .REACH_BITS(REACH_BITS)) u_reach (
        .addr(cfg_addr), .len(cfg_len), .in_range(in_range)
    );

    dma_eng_seq #(.REG_W(REG_W), .DATA_W(DATA_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_cmd(start_cmd), .stop_cmd(stop_cmd),
        .ack_cmd(ack_cmd), .in_range(in_range), .cfg_addr(cfg_addr),
        .cfg_len(cfg_len), .cfg_to_dev(cfg_to_dev), .busy(busy),
        .irq_flag(irq), .err_flag(err_flag), .remaining(remaining),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .dev_rd_en(dev_rd_en), .dev_rdata(dev_rdata),
        .dev_wr_en(dev_wr_en), .dev_wdata(dev_wdata)
    );
endmodule

// File: tb/dma_engine_test.sv
module dma_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        irq, mem_req, mem_we, mem_ack, dev_rd_en, dev_wr_en;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, dev_rdata, dev_wdata;

    int checks = 0;
    int fails = 0;
    int stall_mode = 0;
    bit ack_hold = 0;
    int tick = 0;
    logic [31:0] pop_cnt = 0;
    bit pop_pend = 0;
    int rd_n = 0, wr_n = 0, dv_n = 0;
    logic [31:0] rd_a [16];
    logic [31:0] wr_a [16];
    logic [31:0] wr_d [16];
    logic [31:0] dv_d [16];

    always #5 clk = ~clk;

    dma_engine uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .dev_rd_en(dev_rd_en), .dev_rdata(dev_rdata),
        .dev_wr_en(dev_wr_en), .dev_wdata(dev_wdata)
    );

    function automatic logic [31:0] memf(input logic [31:0] a);
        return a ^ 32'h3C3C_A5A5;
    endfunction

    assign dev_rdata = 32'hC000_0000 + pop_cnt;

    // Memory and device models, evaluated on falling edges.
    initial mem_ack = 1'b0;
    initial mem_rdata = 32'd0;
    always @(negedge clk) begin
        if (pop_pend) pop_cnt = pop_cnt + 1;
        pop_pend = dev_rd_en;
        if (dev_wr_en && dv_n < 16) begin dv_d[dv_n] = dev_wdata; dv_n++; end
        tick++;
        mem_ack = mem_req && !ack_hold && (stall_mode == 0 || tick[0]);
        mem_rdata = memf(mem_addr);
        if (mem_ack) begin
            if (mem_we) begin
                if (wr_n < 16) begin wr_a[wr_n] = mem_addr; wr_d[wr_n] = mem_wdata; end
                wr_n++;
            end else begin
                if (rd_n < 16) rd_a[rd_n] = mem_addr;
                rd_n++;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] off, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = off; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] off, output logic [31:0] d);
        reg_addr = off;
        #1 d = reg_rdata;
    endtask

    task automatic run_xfer(input bit to_dev, input logic [31:0] a,
                            input logic [31:0] n, input int mode);
        int beats;
        int waitc;
        logic [31:0] v;
        beats = int'((n + 32'd3) / 32'd4);
        wr(3'd0, 32'd1);
        wr(3'd0, to_dev ? 32'd2 : 32'd3);
        wr(3'd1, a);
        wr(3'd2, n);
        stall_mode = mode;
        rd_n = 0; wr_n = 0; dv_n = 0; pop_cnt = 0; pop_pend = 0;
        wr(3'd0, 32'd4);
        waitc = 0;
        while (!irq && waitc < 400) begin @(negedge clk); waitc++; end
        @(negedge clk);
        chk("R4 irq raised at completion", {31'd0, irq}, 32'd1);
        rd(3'd3, v);
        chk("R10 status after completion", v, {28'd0, to_dev, 1'b0, 1'b1, 1'b0});
        rd(3'd4, v);
        chk("R9 remaining ends at 0", v, 32'd0);
        if (to_dev) begin
            chk("R2 memory read count", rd_n, beats);
            chk("R2 device push count", dv_n, beats);
            chk("R5 no memory writes", wr_n, 0);
            for (int i = 0; i < beats && i < 16; i++) begin
                chk("R2 read address", rd_a[i], a + 32'(4 * i));
                chk("R2 device data", dv_d[i], memf(a + 32'(4 * i)));
            end
        end else begin
            chk("R3 memory write count", wr_n, beats);
            chk("R5 no memory reads", rd_n, 0);
            chk("R3 device pops", pop_cnt, 32'(beats));
            for (int i = 0; i < beats && i < 16; i++) begin
                chk("R3 write address", wr_a[i], a + 32'(4 * i));
                chk("R3 write data", wr_d[i], 32'hC000_0000 + 32'(i));
            end
        end
        repeat (3) @(negedge clk);
        chk("R4 irq held until acknowledge", {31'd0, irq}, 32'd1);
        wr(3'd0, 32'd5);
        chk("R4 irq cleared by acknowledge", {31'd0, irq}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(3'd3, v); chk("R1 status after reset", v, 32'd0);
        rd(3'd4, v); chk("R1 remaining after reset", v, 32'd0);
        chk("R1 outputs idle", {28'd0, irq, mem_req, dev_rd_en, dev_wr_en}, 32'd0);
        rd(3'd0, v); chk("R10 command register reads 0", v, 32'd0);

        // Sweep both directions, lengths 0..12, two bases, two ack patterns.
        for (int d = 0; d < 2; d++)
            for (int m = 0; m < 2; m++)
                for (int ai = 0; ai < 2; ai++)
                    for (int n = 0; n <= 12; n++)
                        run_xfer(d[0], ai == 0 ? 32'h0000_1000 : 32'h00FF_FFC0,
                                 32'(n), m);

        // R6: reachability limits.
        run_xfer(1'b1, 32'h00FF_FFFC, 32'd4, 0);
        wr(3'd1, 32'h00FF_FFFC); wr(3'd2, 32'd5); wr(3'd0, 32'd4);
        rd(3'd3, v); chk("R6 end past reach refused", v, 32'h0000_000C);
        chk("R6 no request when refused", {31'd0, mem_req}, 32'd0);
        wr(3'd0, 32'd1);
        rd(3'd3, v); chk("R6 stop clears error", v, 32'h0000_0008);
        wr(3'd1, 32'h0100_0000); wr(3'd2, 32'd0); wr(3'd0, 32'd4);
        rd(3'd3, v); chk("R6 start past reach refused", v, 32'h0000_000C);
        chk("R6 no irq when refused", {31'd0, irq}, 32'd0);
        wr(3'd1, 32'h0000_1000); wr(3'd0, 32'd4);
        rd(3'd3, v); chk("R6 accepted go clears error, R5 irq", v, 32'h0000_000A);
        wr(3'd0, 32'd5);

        // R7, R8, R9: frozen registers, single beats, stop.
        wr(3'd0, 32'd1); wr(3'd0, 32'd3);
        wr(3'd1, 32'h0000_2000); wr(3'd2, 32'd10);
        ack_hold = 1;
        rd_n = 0; wr_n = 0; dv_n = 0; pop_cnt = 0; pop_pend = 0;
        wr(3'd0, 32'd4);
        rd(3'd3, v); chk("R10 status busy device-to-memory", v, 32'h0000_0001);
        rd(3'd4, v); chk("R9 remaining loaded at go", v, 32'd10);
        wr(3'd1, 32'h0000_3000); wr(3'd2, 32'd99);
        wr(3'd0, 32'd2); wr(3'd0, 32'd4);
        rd(3'd1, v); chk("R7 address write ignored", v, 32'h0000_2000);
        rd(3'd2, v); chk("R7 length write ignored", v, 32'd10);
        rd(3'd3, v); chk("R7 direction and go ignored", v, 32'h0000_0001);
        rd(3'd4, v); chk("R7 remaining untouched", v, 32'd10);
        #2 ack_hold = 0;
        @(negedge clk);
        #2 ack_hold = 1;
        @(negedge clk);
        rd(3'd4, v); chk("R9 remaining after one beat", v, 32'd6);
        chk("R3 single beat write count", wr_n, 1);
        chk("R3 single beat data", wr_d[0], 32'hC000_0000);
        wr(3'd0, 32'd1);
        rd(3'd3, v); chk("R8 stop idles engine", v, 32'd0);
        chk("R8 request dropped, no irq", {30'd0, mem_req, irq}, 32'd0);
        ack_hold = 0;
        repeat (5) @(negedge clk);
        chk("R8 no beats after stop", wr_n, 1);
        rd(3'd4, v); chk("R9 remaining holds after stop", v, 32'd6);
        wr(3'd1, 32'h0000_4000); wr(3'd2, 32'd8);
        rd(3'd1, v); chk("R8 address reload after stop", v, 32'h0000_4000);
        rd(3'd2, v); chk("R8 length reload after stop", v, 32'd8);
        run_xfer(1'b0, 32'h0000_4000, 32'd8, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule